// File: doc/BRIEF.md
# Combining Fetch-and-Add Unit

This block is a shared counter bank for a many-core array. It keeps a handful of global 32-bit counters and serves atomic fetch-and-add requests from every thread control unit at once. Each requester names a counter and offers an increment of 0 or 1. In the same cycle, all requests that aim at one counter are merged by a parallel-prefix count. The counter then moves forward by the number of 1-increments it received, and each requester gets back the old counter value plus the number of 1-increment requesters on lower ports that named the same counter. Concurrent claimers therefore receive consecutive, distinct slot numbers. A typical use is scattering the surviving elements of an array into a dense output during compaction.

The merge takes a fixed number of cycles for any number of requesters. A fresh batch is accepted on every clock, and every batch sees the effect of the one before it. A serial-mode master can load any counter through a separate write port. A load issued in the same cycle as a batch is applied before that batch is merged.

Top module: `psum_combiner`

## Requirements
- R1: A valid request with increment 1 returns the counter value held before its batch (plus its rank, see R3), and the counter grows by one for it.
- R2: A valid request with increment 0 returns the current counter value (plus its rank) and does not change the counter.
- R3: Within one batch, requester k on counter c receives base(c) + the number of valid increment-1 requesters with a lower port index that also name c. Increment-1 claimers on one counter therefore get distinct, consecutive values.
- R4: After a batch, counter c equals its prior value plus the count of valid increment-1 requests that named c.
- R5: Requests that name different counters in the same batch are merged independently of one another.
- R6: req_ready is always high. A request accepted at rising edge n has its rsp_valid bit and rsp_value lane valid after rising edge n+1 (two-cycle latency). Batches may come on every cycle, and each batch observes the updates of all earlier batches.
- R7: When the counter-write port is active in the same cycle as a batch, the written value replaces the counter before that batch is merged. A write with no requests simply loads the counter.
- R8: Counters wrap modulo 2^32. Returned values wrap the same way.
- R9: Reset clears every counter to zero and drops all rsp_valid bits.
- R10: Request index field k of req_idx is bits [k*IW +: IW], with IW = 3 for 8 counters. Response lane k is rsp_value[k*32 +: 32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Per-requester request valid |
| req_ready | output | NREQ | Per-requester ready, always high |
| req_idx | input | NREQ*IW | Counter index per requester |
| req_inc | input | NREQ | Increment per requester (0 or 1) |
| base_wr_en | input | 1 | Counter load strobe from the serial master |
| base_wr_sel | input | IW | Counter to load |
| base_wr_data | input | DW | Value to load |
| rsp_valid | output | NREQ | Per-requester response valid |
| rsp_value | output | NREQ*DW | Per-requester returned value |

## Verification
Several request patterns are used:
- All 64 ports claim one counter. This separates a correct rank count from one that counts the wrong side of the port or drops a lane.
- Mixes of increment 0 and 1 show whether read-only requests disturb ranks or counters.
- Random counter indices with random valids show whether counters interfere across indices.
- A load in the same cycle as a batch, and a load near 2^32, check load ordering and wrap-around.
- Back-to-back random batches check that each batch sees the previous batch's update at the two-cycle latency.

// File: rtl/psum_pkg.sv
package psum_pkg;
    localparam int PS_NREQ  = 64;
    localparam int PS_NBASE = 8;
    localparam int PS_DW    = 32;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/psum_scan.sv
// Kogge-Stone exclusive count of set bits below each position.
module psum_scan #(
    parameter int N  = 64,
    parameter int CW = 7
) (
    input  logic [N-1:0]         bits,
    output logic [N-1:0][CW-1:0] excl,
    output logic [CW-1:0]        total
);
    localparam int LV = (N > 1) ? $clog2(N) : 0;

    logic [CW-1:0] lv [0:LV][0:N-1];

    for (genvar j = 0; j < N; j++) begin : g_leaf
        assign lv[0][j] = CW'(bits[j]);
    end

    for (genvar s = 0; s < LV; s++) begin : g_level
        for (genvar j = 0; j < N; j++) begin : g_node
            if (j >= (1 << s)) begin : g_add
                assign lv[s+1][j] = lv[s][j] + lv[s][j - (1 << s)];
            end else begin : g_pass
                assign lv[s+1][j] = lv[s][j];
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        assign excl[j] = lv[LV][j] - CW'(bits[j]);
    end

    assign total = lv[LV][N-1];
endmodule

// File: rtl/psum_bank.sv
// Counter registers with write-before-merge forwarding.
module psum_bank #(
    parameter int NBASE = 8,
    parameter int DW    = 32,
    parameter int CW    = 7,
    parameter int IW    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_sel,
    input  logic [DW-1:0]              wr_data,
    input  logic [NBASE-1:0][CW-1:0]   add_total,
    output logic [NBASE-1:0][DW-1:0]   eff_base
);
    logic [NBASE-1:0][DW-1:0] base_q;

    always_comb begin
        for (int b = 0; b < NBASE; b++) begin
            eff_base[b] = (wr_en && wr_sel == IW'(b)) ? wr_data : base_q[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            for (int b = 0; b < NBASE; b++) begin
                base_q[b] <= eff_base[b] + DW'(add_total[b]);
            end
        end
    end

    for (genvar b = 0; b < NBASE; b++) begin : g_chk
        // R2: no load and no claimers leaves the counter untouched
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_sel == IW'(b)) && add_total[b] == '0) |=> $stable(base_q[b]));
    end
endmodule

// File: rtl/psum_combiner.sv
module psum_combiner
    import psum_pkg::*;
#(
    parameter int NREQ  = PS_NREQ,
    parameter int NBASE = PS_NBASE,
    parameter int DW    = PS_DW,
    parameter int IW    = idx_width(PS_NBASE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_valid,
    output logic [NREQ-1:0]      req_ready,
    input  logic [NREQ*IW-1:0]   req_idx,
    input  logic [NREQ-1:0]      req_inc,
    input  logic                 base_wr_en,
    input  logic [IW-1:0]        base_wr_sel,
    input  logic [DW-1:0]        base_wr_data,
    output logic [NREQ-1:0]      rsp_valid,
    output logic [NREQ*DW-1:0]   rsp_value
);
    localparam int CW = $clog2(NREQ + 1);

    // Stage 1: captured batch and load
    logic [NREQ-1:0]          s1_vld;
    logic [NREQ-1:0]          s1_inc;
    logic [NREQ-1:0][IW-1:0]  s1_idx;
    logic                     s1_wr_en;
    logic [IW-1:0]            s1_wr_sel;
    logic [DW-1:0]            s1_wr_data;

    // Merge network
    logic [NBASE-1:0][NREQ-1:0]          hit;
    logic [NBASE-1:0][NREQ-1:0][CW-1:0]  pre;
    logic [NBASE-1:0][CW-1:0]            tot;
    logic [NBASE-1:0][DW-1:0]            eff_base;
    logic [NREQ-1:0][CW-1:0]             rank;
    logic [NREQ-1:0][DW-1:0]             slot;

    // Stage 2: response registers
    logic [NREQ-1:0]          rsp_valid_q;
    logic [NREQ-1:0][DW-1:0]  rsp_value_q;

    assign req_ready = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld     <= '0;
            s1_inc     <= '0;
            s1_idx     <= '0;
            s1_wr_en   <= 1'b0;
            s1_wr_sel  <= '0;
            s1_wr_data <= '0;
        end else begin
            s1_vld     <= req_valid & req_ready;
            s1_inc     <= req_inc;
            s1_idx     <= req_idx;
            s1_wr_en   <= base_wr_en;
            s1_wr_sel  <= base_wr_sel;
            s1_wr_data <= base_wr_data;
        end
    end

    always_comb begin
        for (int b = 0; b < NBASE; b++) begin
            for (int k = 0; k < NREQ; k++) begin
                hit[b][k] = s1_vld[k] && s1_inc[k] && (s1_idx[k] == IW'(b));
            end
        end
    end

    for (genvar b = 0; b < NBASE; b++) begin : g_scan
        psum_scan #(.N(NREQ), .CW(CW)) u_scan (
            .bits  (hit[b]),
            .excl  (pre[b]),
            .total (tot[b])
        );
    end

    psum_bank #(.NBASE(NBASE), .DW(DW), .CW(CW), .IW(IW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (s1_wr_en),
        .wr_sel    (s1_wr_sel),
        .wr_data   (s1_wr_data),
        .add_total (tot),
        .eff_base  (eff_base)
    );

    always_comb begin
        for (int k = 0; k < NREQ; k++) begin
            rank[k] = pre[s1_idx[k]][k];
            slot[k] = eff_base[s1_idx[k]] + DW'(rank[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= '0;
            rsp_value_q <= '0;
        end else begin
            rsp_valid_q <= s1_vld;
            rsp_value_q <= slot;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_value = rsp_value_q;

    // R6: a response only for a request presented two edges earlier
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid & ~$past(req_valid, 2)) == '0);

    for (genvar b = 0; b < NBASE; b++) begin : g_tot_chk
        // R4: counter advance equals the number of claimers on it
        assert_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(tot[b]) == $countones(hit[b]));
    end

    for (genvar k = 0; k < NREQ; k++) begin : g_rank_chk
        // R3: rank can never exceed the number of lower ports
        assert_rank_R3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(rank[k]) <= k);
        // R7: a same-cycle load is seen by the requests of that batch
        assert_write_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_wr_en && s1_vld[k] && s1_idx[k] == s1_wr_sel)
            |=> (rsp_value_q[k] - $past(s1_wr_data)) <= DW'(k));
    end
endmodule

// File: tb/psum_combiner_test.sv
module psum_combiner_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ  = 64;
    localparam int NBASE = 8;
    localparam int DW    = 32;
    localparam int IW    = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NREQ-1:0]     req_valid = '0;
    logic [NREQ-1:0]     req_ready;
    logic [NREQ*IW-1:0]  req_idx = '0;
    logic [NREQ-1:0]     req_inc = '0;
    logic                base_wr_en = 1'b0;
    logic [IW-1:0]       base_wr_sel = '0;
    logic [DW-1:0]       base_wr_data = '0;
    logic [NREQ-1:0]     rsp_valid;
    logic [NREQ*DW-1:0]  rsp_value;

    psum_combiner uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .req_inc(req_inc),
        .base_wr_en(base_wr_en), .base_wr_sel(base_wr_sel), .base_wr_data(base_wr_data),
        .rsp_valid(rsp_valid), .rsp_value(rsp_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state and next-batch stimulus
    logic [DW-1:0] ref_base [NBASE];
    bit [NREQ-1:0] nv, ninc;
    logic [IW-1:0] nidx [NREQ];
    bit            nwe;
    logic [IW-1:0] nws;
    logic [DW-1:0] nwd;

    // Two-deep expectation pipeline
    logic [DW-1:0] exp1 [NREQ];
    logic [DW-1:0] exp2 [NREQ];
    bit [NREQ-1:0] ev1 = '0, ev2 = '0;
    string tg1 = "R6", tg2 = "R6";

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic void model();
        logic [DW-1:0] eb [NBASE];
        int cnt [NBASE];
        for (int b = 0; b < NBASE; b++) begin
            eb[b] = ref_base[b];
            cnt[b] = 0;
        end
        if (nwe) eb[nws] = nwd;
        for (int k = 0; k < NREQ; k++) begin
            exp1[k] = '0;
            if (nv[k]) begin
                exp1[k] = eb[nidx[k]] + DW'(cnt[nidx[k]]);
                if (ninc[k]) cnt[nidx[k]]++;
            end
        end
        for (int b = 0; b < NBASE; b++) ref_base[b] = eb[b] + DW'(cnt[b]);
        ev1 = nv;
    endfunction

    task automatic step(input string tag);
        @(negedge clk);
        chk(rsp_valid == ev2, tg2, DW'(rsp_valid), DW'(ev2));
        for (int k = 0; k < NREQ; k++) begin
            if (ev2[k]) chk(rsp_value[k*DW +: DW] == exp2[k], tg2, rsp_value[k*DW +: DW], exp2[k]);
        end
        exp2 = exp1;
        ev2 = ev1;
        tg2 = tg1;
        model();
        tg1 = tag;
        req_valid = nv;
        req_inc = ninc;
        for (int k = 0; k < NREQ; k++) req_idx[k*IW +: IW] = nidx[k];
        base_wr_en = nwe;
        base_wr_sel = nws;
        base_wr_data = nwd;
    endtask

    task automatic clear_next();
        nv = '0; ninc = '0; nwe = 0; nws = '0; nwd = '0;
        for (int k = 0; k < NREQ; k++) nidx[k] = '0;
    endtask

    task automatic flush();
        clear_next();
        step("R6");
        step("R6");
        step("R6");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd77211));
        for (int b = 0; b < NBASE; b++) ref_base[b] = '0;
        for (int k = 0; k < NREQ; k++) begin exp1[k] = '0; exp2[k] = '0; end
        clear_next();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: outputs cleared by reset; R6: ready held high
        chk(rsp_valid == '0, "R9", DW'(rsp_valid), '0);
        chk(req_ready == '1, "R6", DW'(req_ready), '1);

        // R9: every counter reads zero after reset (R10 field layout)
        clear_next();
        for (int k = 0; k < NREQ; k++) begin nv[k] = 1; nidx[k] = IW'(k % NBASE); end
        step("R9");
        flush();

        // R1: single claimer, repeated
        for (int i = 0; i < 4; i++) begin
            clear_next(); nv[5] = 1; ninc[5] = 1; nidx[5] = 3'd3;
            step("R1");
        end
        flush();

        // R3: all ports claim counter 6 in one batch
        clear_next();
        for (int k = 0; k < NREQ; k++) begin nv[k] = 1; ninc[k] = 1; nidx[k] = 3'd6; end
        step("R3");
        // R4: read back counter 6 after the batch
        clear_next(); nv[0] = 1; nidx[0] = 3'd6;
        step("R4");
        flush();

        // R2: mixed increments 0/1 on one counter
        clear_next();
        for (int k = 0; k < NREQ; k++) begin nv[k] = 1; ninc[k] = k[0]; nidx[k] = 3'd2; end
        step("R2");
        clear_next();
        for (int k = 0; k < NREQ; k++) begin nv[k] = 1; nidx[k] = 3'd2; end
        step("R2");
        flush();

        // R7: load in the same cycle as a batch on the loaded counter
        clear_next();
        nwe = 1; nws = 3'd1; nwd = 32'h1000_0000;
        for (int k = 0; k < NREQ; k += 3) begin nv[k] = 1; ninc[k] = 1; nidx[k] = 3'd1; end
        step("R7");
        clear_next(); nwe = 1; nws = 3'd4; nwd = 32'hABCD_0123;
        step("R7");
        clear_next(); nv[9] = 1; nidx[9] = 3'd4;
        step("R7");
        flush();

        // R8: wrap past 2^32
        clear_next(); nwe = 1; nws = 3'd7; nwd = 32'hFFFF_FFF0;
        for (int k = 0; k < NREQ; k++) begin nv[k] = 1; ninc[k] = 1; nidx[k] = 3'd7; end
        step("R8");
        clear_next(); nv[63] = 1; nidx[63] = 3'd7;
        step("R8");
        flush();

        // R5: random indices, all valid, all claiming
        for (int i = 0; i < 20; i++) begin
            clear_next();
            for (int k = 0; k < NREQ; k++) begin nv[k] = 1; ninc[k] = 1; nidx[k] = IW'($urandom_range(0, NBASE-1)); end
            step("R5");
        end
        flush();

        // R6: back-to-back random batches with random loads
        for (int i = 0; i < 300; i++) begin
            clear_next();
            for (int k = 0; k < NREQ; k++) begin
                nv[k] = $urandom_range(0, 3) != 0;
                ninc[k] = $urandom_range(0, 1) != 0;
                nidx[k] = IW'($urandom_range(0, NBASE-1));
            end
            if ($urandom_range(0, 9) == 0) begin
                nwe = 1; nws = IW'($urandom_range(0, NBASE-1)); nwd = $urandom();
            end
            step("R6");
        end
        flush();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule